// File: doc/BRIEF.md
# Multi-Mode Asynchronous Serial Transmitter

This block turns one parallel data word per request into an asynchronous serial frame on a single output line. A frame is a low start bit, the data bits with the least significant bit first, an optional extra bit, and one or two high stop bits. The extra bit is either a parity bit or an address/data marker, depending on the operating mode. Words arrive on a valid/ready input. Bit timing comes from a baud-tick input, and each bit is held for a fixed number of ticks (16 by default).

Control inputs choose the data length, parity on/off, parity sense, stop length, the operating mode and transmit enable. The mode can change the frame. Normal mode (0) honours every control. Multiprocessor mode (1) replaces parity with a programmable address/data flag. LIN mode (3) always sends 8 data bits, no parity and one stop bit. Encoding 2 is handled as a fixed 8-bit frame. All controls are captured when a word is accepted and stay fixed for the rest of that frame.

The controller has six states. ST_IDLE holds the line high and offers ready. ST_START drives the start bit. ST_DATA shifts out the data bits. ST_EXTRA drives the parity or flag bit. ST_STOP1 and ST_STOP2 drive the stop bits. The transitions are:
- IDLE→START on an accepted word.
- START→DATA at the end of the bit.
- DATA→EXTRA or DATA→STOP1 after the last data bit, depending on whether an extra bit is due.
- EXTRA→STOP1 at the end of the bit.
- STOP1→STOP2 when two stop bits are selected, otherwise STOP1→IDLE.
- STOP2→IDLE at the end of the bit.

Top module: `mmtx_top`

## Requirements
- R1: While no frame is in progress, `txd` is high. `in_ready` is high only in that idle state and only while `tx_en` is 1. `in_ready` falls in the cycle after a word is accepted and stays low until the last stop bit has ended.
- R2: A word is accepted on a clock edge where `in_valid` and `in_ready` are both high. The start bit (low) appears on `txd` in the following cycle.
- R3: Every bit of a frame lasts exactly 16 baud ticks. Data bits go out least significant bit first. `len8` = 0 sends the low 7 bits, and `len8` = 1 sends 8 bits.
- R4: In mode 0 with `par_en` = 1, a parity bit follows the data. With `par_odd` = 0 the count of ones over the sent data bits plus parity is even. With `par_odd` = 1 that count is odd.
- R5: In mode 1, the bit directly after the data is the value of `addr_flag` at acceptance (1 = address, 0 = data), and no parity bit is sent, whatever `par_en` is set to.
- R6: In mode 3, the frame always has 8 data bits, no parity and one stop bit, whatever `len8`, `par_en` and `stop2` are set to.
- R7: In mode 2, the frame has 8 data bits and no parity bit, and the stop length follows `stop2`.
- R8: `stop2` = 0 gives one stop bit and `stop2` = 1 gives two stop bits, both high.
- R9: While `tx_en` is 0, no word is accepted, even with `in_valid` held high, and `txd` stays high.
- R10: A frame that has started runs to its end even if `tx_en` is cleared partway through it.
- R11: Changes to `mode`, `len8`, `par_en`, `par_odd`, `stop2` or `addr_flag` during a frame have no effect on that frame.
- R12: `txd` changes only on a clock edge that consumes a baud tick or that accepts a word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmit enable |
| mode | input | 2 | Operating mode: 0 normal, 1 multiprocessor, 2 fixed 8-bit, 3 LIN |
| len8 | input | 1 | Data length: 0 = 7 bits, 1 = 8 bits |
| par_en | input | 1 | Parity enable (used only in mode 0) |
| par_odd | input | 1 | Parity sense: 0 even, 1 odd |
| stop2 | input | 1 | Stop length: 0 one bit, 1 two bits |
| addr_flag | input | 1 | Address/data flag for mode 1 |
| in_valid | input | 1 | Data word offered |
| in_data | input | DW (8) | Data word |
| in_ready | output | 1 | Block can accept a word |
| baud_tick | input | 1 | Baud-rate tick, one clock wide |
| txd | output | 1 | Serial output, idles high |

## Verification
Two events can fall in the same stretch of time: clearing transmit enable and the finishing of a frame that is already on the line. The bench drops `tx_en`, and rewrites every format control, during the second data bit of a frame. It then checks every remaining bit against the format captured at acceptance. Afterwards it holds `in_valid` high with `tx_en` low for a long window, and requires `txd` to stay high and `in_ready` to stay low for every cycle of it. A second case checks a new word offered in the very first idle cycle after a stop bit, which must start a new frame at once.

// File: rtl/mmtx_pkg.sv
package mmtx_pkg;

    localparam logic [1:0] MODE_NORMAL = 2'd0;
    localparam logic [1:0] MODE_MPROC  = 2'd1;
    localparam logic [1:0] MODE_FIXED8 = 2'd2;
    localparam logic [1:0] MODE_LIN    = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_EXTRA,
        ST_STOP1,
        ST_STOP2
    } tx_state_e;

    // Frame format after the mode rules are applied
    typedef struct packed {
        logic len8;       // 1: full word, 0: word minus top bit
        logic extra_en;   // an extra bit follows the data
        logic use_flag;   // extra bit is the address/data flag
        logic par_odd;    // parity sense
        logic flag;       // address/data flag value
        logic stop2;      // two stop bits
    } frame_cfg_t;

endpackage

// File: rtl/mmtx_cfg_resolve.sv
module mmtx_cfg_resolve
    import mmtx_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       len8,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       stop2,
    input  logic       addr_flag,
    output frame_cfg_t cfg
);

    always_comb begin
        cfg          = '0;
        cfg.par_odd  = par_odd;
        cfg.flag     = addr_flag;
        unique case (mode)
            MODE_NORMAL: begin
                cfg.len8     = len8;
                cfg.extra_en = par_en;
                cfg.use_flag = 1'b0;
                cfg.stop2    = stop2;
            end
            MODE_MPROC: begin
                cfg.len8     = len8;
                cfg.extra_en = 1'b1;
                cfg.use_flag = 1'b1;
                cfg.stop2    = stop2;
            end
            MODE_FIXED8: begin
                cfg.len8     = 1'b1;
                cfg.extra_en = 1'b0;
                cfg.use_flag = 1'b0;
                cfg.stop2    = stop2;
            end
            MODE_LIN: begin
                cfg.len8     = 1'b1;
                cfg.extra_en = 1'b0;
                cfg.use_flag = 1'b0;
                cfg.stop2    = 1'b0;
            end
            default: cfg = '0;
        endcase
    end

endmodule

// File: rtl/mmtx_bit_timer.sv
module mmtx_bit_timer #(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic baud_tick,
    output logic bit_end
);

    localparam int CW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_BIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (baud_tick) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    assign bit_end = run && baud_tick && (cnt == LAST);

endmodule

// File: rtl/mmtx_shifter.sv
module mmtx_shifter #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          shift,
    input  logic [DW-1:0] load_data,
    input  logic          len8,
    input  logic          par_odd,
    input  logic          use_flag,
    input  logic          flag,
    output logic          lsb,
    output logic          last,
    output logic          extra_bit
);

    localparam int BW = $clog2(DW + 1);
    localparam logic [DW-1:0] SHORT_MASK = {1'b0, {(DW-1){1'b1}}};

    logic [DW-1:0] shreg;
    logic [BW-1:0] bits_left;
    logic          extra_q;
    logic [DW-1:0] masked;

    assign masked = load_data & (len8 ? {DW{1'b1}} : SHORT_MASK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg     <= '0;
            bits_left <= '0;
            extra_q   <= 1'b0;
        end else if (load) begin
            shreg     <= masked;
            bits_left <= len8 ? BW'(DW) : BW'(DW - 1);
            extra_q   <= use_flag ? flag : ((^masked) ^ par_odd);
        end else if (shift) begin
            shreg     <= shreg >> 1;
            bits_left <= bits_left - 1'b1;
        end
    end

    assign lsb       = shreg[0];
    assign last      = (bits_left == BW'(1));
    assign extra_bit = extra_q;

endmodule

// File: rtl/mmtx_top.sv
module mmtx_top
    import mmtx_pkg::*;
#(
    parameter int DW            = 8,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_en,
    input  logic [1:0]    mode,
    input  logic          len8,
    input  logic          par_en,
    input  logic          par_odd,
    input  logic          stop2,
    input  logic          addr_flag,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          in_ready,
    input  logic          baud_tick,
    output logic          txd
);

    tx_state_e  state, state_nx;
    frame_cfg_t cfg_now, cfg_q;
    logic       accept, bit_end, run;
    logic       sh_lsb, sh_last, sh_extra;

    mmtx_cfg_resolve u_cfg (
        .mode      (mode),
        .len8      (len8),
        .par_en    (par_en),
        .par_odd   (par_odd),
        .stop2     (stop2),
        .addr_flag (addr_flag),
        .cfg       (cfg_now)
    );

    assign run    = (state != ST_IDLE);
    assign accept = in_valid && in_ready;

    mmtx_bit_timer #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .baud_tick (baud_tick),
        .bit_end   (bit_end)
    );

    mmtx_shifter #(.DW(DW)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .shift     ((state == ST_DATA) && bit_end),
        .load_data (in_data),
        .len8      (cfg_now.len8),
        .par_odd   (cfg_now.par_odd),
        .use_flag  (cfg_now.use_flag),
        .flag      (cfg_now.flag),
        .lsb       (sh_lsb),
        .last      (sh_last),
        .extra_bit (sh_extra)
    );

    // Format captured at acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (accept) begin
            cfg_q <= cfg_now;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (accept)  state_nx = ST_START;
            ST_START: if (bit_end) state_nx = ST_DATA;
            ST_DATA:  if (bit_end && sh_last)
                          state_nx = cfg_q.extra_en ? ST_EXTRA : ST_STOP1;
            ST_EXTRA: if (bit_end) state_nx = ST_STOP1;
            ST_STOP1: if (bit_end)
                          state_nx = cfg_q.stop2 ? ST_STOP2 : ST_IDLE;
            ST_STOP2: if (bit_end) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        in_ready = 1'b0;
        txd      = 1'b1;
        unique case (state)
            ST_IDLE:  in_ready = tx_en;
            ST_START: txd = 1'b0;
            ST_DATA:  txd = sh_lsb;
            ST_EXTRA: txd = sh_extra;
            ST_STOP1: txd = 1'b1;
            ST_STOP2: txd = 1'b1;
            default:  txd = 1'b1;
        endcase
    end

endmodule

// File: rtl/mmtx_top_chk.sv
module mmtx_top_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic in_valid,
    input logic in_ready,
    input logic baud_tick,
    input logic txd
);

    // R1
    ready_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> txd);

    // R1
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R2
    start_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !txd);

    // R9
    disabled_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> !in_ready);

    // R12
    line_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!baud_tick && !(in_valid && in_ready)) |=> $stable(txd));

endmodule

bind mmtx_top mmtx_top_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (tx_en),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .baud_tick (baud_tick),
    .txd       (txd)
);

// File: tb/test_mmtx_top.sv
module test_mmtx_top;

    typedef struct packed {
        logic [1:0] mode;
        logic       len8;
        logic       pen;
        logic       podd;
        logic       stop2;
        logic       flag;
        logic [7:0] data;
        logic [3:0] nbits;   // total frame bits, start to last stop
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 4'd10},  // R3 plain 8N1
        '{2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h53, 4'd10},  // R4 7 bits even
        '{2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'h0F, 4'd12},  // R4 R8 odd, 2 stop
        '{2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'hFF, 4'd10},  // R3 top bit dropped
        '{2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h3C, 4'd11},  // R5 address
        '{2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'hA2, 4'd11},  // R5 data frame
        '{2'd3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h81, 4'd10},  // R6 LIN forced
        '{2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'hC3, 4'd11}   // R7 fixed 8
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       len8 = 1'b1, par_en = 1'b0, par_odd = 1'b0, stop2 = 1'b0, addr_flag = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready;
    logic       baud_tick = 1'b0;
    logic       txd;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    mmtx_top i_mmtx_top (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .mode(mode), .len8(len8),
        .par_en(par_en), .par_odd(par_odd), .stop2(stop2), .addr_flag(addr_flag),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .baud_tick(baud_tick), .txd(txd)
    );

    always #10 clk = ~clk;

    // tick every other cycle, updated just after the rising edge
    initial forever begin
        @(posedge clk);
        baud_tick <= ~baud_tick;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic count_ticks(input int n);
        int seen = 0;
        forever begin
            if (baud_tick) seen++;
            if (seen == n) break;
            @(negedge clk);
        end
    endtask

    // Expected frame built from the requirements
    function automatic void build(input vec_t v, output logic [11:0] bits, output int n);
        int  dl;
        bit  extra_en, extra_v, two;
        logic [7:0] d;
        dl = (v.mode == 2'd0 || v.mode == 2'd1) ? (v.len8 ? 8 : 7) : 8;
        d  = (dl == 7) ? (v.data & 8'h7F) : v.data;
        extra_en = (v.mode == 2'd1) || (v.mode == 2'd0 && v.pen);
        extra_v  = (v.mode == 2'd1) ? v.flag : ((^d) ^ v.podd);
        two      = (v.mode != 2'd3) && v.stop2;
        bits = '1;
        bits[0] = 1'b0;
        n = 1;
        for (int i = 0; i < dl; i++) begin bits[n] = d[i]; n++; end
        if (extra_en) begin bits[n] = extra_v; n++; end
        bits[n] = 1'b1; n++;
        if (two) begin bits[n] = 1'b1; n++; end
    endfunction

    // Send one frame and check every bit at its middle
    task automatic run_frame(input vec_t v, input bit disturb, input string req);
        logic [11:0] exp_bits;
        int          n;
        build(v, exp_bits, n);
        check(n == int'(v.nbits), {req, " frame length"}, n, int'(v.nbits));
        mode = v.mode; len8 = v.len8; par_en = v.pen; par_odd = v.podd;
        stop2 = v.stop2; addr_flag = v.flag; in_data = v.data; tx_en = 1'b1;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = ~v.data;
        for (int b = 0; b < n; b++) begin
            count_ticks(8);
            check(txd == exp_bits[b], $sformatf("%s bit %0d", req, b), int'(txd), int'(exp_bits[b]));
            check(in_ready == 1'b0, "R1 ready low in frame", int'(in_ready), 0);
            if (disturb && b == 2) begin
                // R10 R11: drop enable and rewrite every control
                tx_en = 1'b0; mode = ~v.mode; len8 = ~v.len8; par_en = ~v.pen;
                par_odd = ~v.podd; stop2 = ~v.stop2; addr_flag = ~v.flag;
            end
            @(negedge clk);
            count_ticks(8);
            @(negedge clk);
        end
        check(txd == 1'b1, {req, " idle after frame"}, int'(txd), 1);
        check(in_ready == tx_en, "R1 ready after frame", int'(in_ready), int'(tx_en));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1 R9: reset state with enable low
        check(txd == 1'b1, "R1 idle line after reset", int'(txd), 1);
        check(in_ready == 1'b0, "R9 no ready while disabled", int'(in_ready), 0);
        rst_n = 1'b1;
        @(negedge clk);
        tx_en = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R1 ready when idle and enabled", int'(in_ready), 1);

        foreach (VECS[k]) begin
            run_frame(VECS[k], 1'b0, $sformatf("R3 vec%0d", k));
        end

        // R9: offer a word while disabled
        tx_en = 1'b0;
        in_valid = 1'b1;
        in_data = 8'h00;
        for (int c = 0; c < 100; c++) begin
            @(negedge clk);
            if (txd != 1'b1 || in_ready != 1'b0)
                check(1'b0, "R9 disabled held", int'({txd, in_ready}), 2);
        end
        check(txd == 1'b1 && in_ready == 1'b0, "R9 no start while disabled", int'({txd, in_ready}), 2);
        in_valid = 1'b0;

        // R10 R11: enable dropped and controls changed mid-frame
        run_frame(VECS[2], 1'b1, "R10 R11 disturbed");
        in_valid = 1'b1;
        for (int c = 0; c < 100; c++) begin
            @(negedge clk);
            if (txd != 1'b1 || in_ready != 1'b0)
                check(1'b0, "R9 after disturbed frame", int'({txd, in_ready}), 2);
        end
        check(txd == 1'b1, "R9 line held high", int'(txd), 1);
        in_valid = 1'b0;

        // R2: back-to-back, second word offered in the first idle cycle
        run_frame(VECS[0], 1'b0, "R2 first");
        run_frame(VECS[6], 1'b0, "R2 back-to-back");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
            $display("  test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

endmodule